// File: doc/BRIEF.md
# Capacitive-Sense Sigma-Delta Conversion Controller

This block is the digital side of a capacitance-to-digital converter that uses a sigma-delta modulator. On each modulation tick it samples a one-bit comparator decision. From that decision it drives an on/off gate for the modulation current source. It also holds the compensation current source statically on or off, depending on whether single-source or dual-source operation is selected.

A conversion starts when software writes a nonzero window length. That length counts down by one on every tick. Meanwhile a result counter accumulates the ticks on which the comparator read high. When the window reaches zero, the result is frozen as the raw count, which is proportional to the sensed capacitance. The window length sets the effective resolution, anywhere from 8 to 16 bits.

Software uses two write addresses:
- **Address 0 (control):** bit 0 master enable, bit 1 polarity (0 source, 1 sink), bit 2 comparator wide bandwidth, bit 3 comparator power, bit 4 sense enable, bit 5 dual-source mode.
- **Address 1 (window):** the upper half loads the window length and the lower half presets the result counter.

Top module: `capsense_sd_ctrl`

## Requirements
- R1: After reset all control bits, the window, the result counter, busy, done and every current-source and comparator output are 0.
- R2: While the master enable (control bit 0) is 0, ticks change neither the window nor the result counter, and the modulation gate, compensation enable and comparator power are all 0.
- R3: During a conversion, each tick whose comparator input is 1 increments the result counter by one; ticks with the comparator at 0 leave it unchanged. The final raw count equals the number of one-samples among the window's ticks.
- R4: Each tick while the window is nonzero decrements it by one. Once it is 0, further ticks change neither the window nor the result counter.
- R5: A write to address 1 in the same cycle as a tick loads the written window and counter values, and the tick has no effect.
- R6: The result counter saturates at its all-ones value instead of wrapping.
- R7: busy is 1 exactly while enabled with a nonzero window. done sets on the tick that brings the window from 1 to 0, and clears when a nonzero window is written.
- R8: With enable and sense enable (control bit 4) both set, the modulation gate equals the comparator value sampled at the latest tick, inverted when polarity (bit 1) is 1. With sense enable at 0 it is 0.
- R9: The compensation-source enable is 1 only when enable, sense enable and dual-source mode (bit 5) are all 1.
- R10: Comparator power equals enable AND control bit 3. The bandwidth output equals the stored control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects window/counter |
| wr_data | input | 2*CW | Write data |
| mod_tick | input | 1 | Single-cycle modulation clock enable |
| cmp_in | input | 1 | Comparator decision |
| mod_gate | output | 1 | Modulation current source on/off |
| comp_src_on | output | 1 | Compensation current source enable |
| cmp_power | output | 1 | Comparator power enable |
| cmp_wide_bw | output | 1 | Comparator bandwidth select |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion finished |
| raw_count | output | CW | Result counter |
| period_left | output | CW | Remaining window ticks |

## Verification
The assertions take `mod_tick` to be a clean single-cycle pulse and `cmp_in` to be a known value whenever a tick is present. They exclude from their step checks any cycle that carries a window write, because that write is defined to override the tick.

The stimulus drives all inputs on the falling edge. Every tick lasts exactly one cycle, with zero to two idle cycles between ticks. Collisions between a write and a tick are created only on purpose, in the R5 case.

// File: rtl/capsense_sd_ctrl.sv
module capsense_sd_ctrl #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [2*CW-1:0] wr_data,
  input  logic            mod_tick,
  input  logic            cmp_in,
  output logic            mod_gate,
  output logic            comp_src_on,
  output logic            cmp_power,
  output logic            cmp_wide_bw,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   raw_count,
  output logic [CW-1:0]   period_left
);
  localparam int DW = 2 * CW;
  localparam logic [CW-1:0] CMAX = '1;

  logic [5:0]    ctl;
  logic [CW-1:0] per, cnt;
  logic          cmp_q, done_q;

  wire en     = ctl[0];
  wire pol    = ctl[1];
  wire sense  = ctl[4];
  wire dual   = ctl[5];
  wire wr_win = wr_en & wr_addr;
  wire step   = en & mod_tick & (per != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ctl <= '0;
    else if (wr_en && !wr_addr)  ctl <= wr_data[5:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per    <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (wr_win) begin
      per <= wr_data[DW-1:CW];
      cnt <= wr_data[CW-1:0];
      if (wr_data[DW-1:CW] != '0) done_q <= 1'b0;
    end else if (step) begin
      per <= per - 1'b1;
      if (cmp_in && cnt != CMAX) cnt <= cnt + 1'b1;
      if (per == CW'(1)) done_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cmp_q <= 1'b0;
    else if (!en)      cmp_q <= 1'b0;
    else if (mod_tick) cmp_q <= cmp_in;

  assign mod_gate    = en & sense & (cmp_q ^ pol);
  assign comp_src_on = en & sense & dual;
  assign cmp_power   = en & ctl[3];
  assign cmp_wide_bw = ctl[2];
  assign busy        = en & (per != '0);
  assign done        = done_q;
  assign raw_count   = cnt;
  assign period_left = per;
endmodule

// File: rtl/capsense_sd_ctrl_checker.sv
module capsense_sd_ctrl_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_addr,
  input logic          mod_tick,
  input logic          cmp_in,
  input logic          en,
  input logic [CW-1:0] per,
  input logic [CW-1:0] cnt,
  input logic          done,
  input logic          busy,
  input logic          mod_gate,
  input logic          comp_src_on,
  input logic          cmp_power
);
  localparam logic [CW-1:0] CMAX = '1;

  p_freeze_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(wr_en && wr_addr)) |=> ($stable(per) && $stable(cnt)));

  p_idle_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!mod_gate && !comp_src_on && !cmp_power && !busy));

  p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mod_tick && per != '0 && cmp_in && cnt != CMAX && !(wr_en && wr_addr))
      |=> cnt == $past(cnt) + 1'b1);

  p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mod_tick && per != '0 && !(wr_en && wr_addr)) |=> per == $past(per) - 1'b1);

  p_halt_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per == '0 && !(wr_en && wr_addr)) |=> (per == '0 && $stable(cnt)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !(wr_en && wr_addr)) |=> cnt == CMAX);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (per == '0 && !busy));
endmodule

bind capsense_sd_ctrl capsense_sd_ctrl_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .mod_tick(mod_tick), .cmp_in(cmp_in), .en(en), .per(per), .cnt(cnt),
  .done(done), .busy(busy), .mod_gate(mod_gate),
  .comp_src_on(comp_src_on), .cmp_power(cmp_power)
);

// File: tb/capsense_sd_ctrl_bench.sv
module capsense_sd_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_addr = 0, mod_tick = 0, cmp_in = 0;
  logic [2*CW-1:0] wr_data = '0;
  logic mod_gate, comp_src_on, cmp_power, cmp_wide_bw, busy, done;
  logic [CW-1:0] raw_count, period_left;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  capsense_sd_ctrl #(.CW(CW)) u_capsense_sd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mod_tick(mod_tick), .cmp_in(cmp_in), .mod_gate(mod_gate),
    .comp_src_on(comp_src_on), .cmp_power(cmp_power), .cmp_wide_bw(cmp_wide_bw),
    .busy(busy), .done(done), .raw_count(raw_count), .period_left(period_left)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [2*CW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic tick(logic c);
    mod_tick = 1; cmp_in = c;
    @(posedge clk); @(negedge clk);
    mod_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {mod_gate, comp_src_on, cmp_power, cmp_wide_bw, busy, done}, 0);
    check("R1 counters", {period_left, raw_count}, 0);

    // R2 disabled: window loaded but frozen
    wr(1, {16'd6, 16'd0});
    for (int i = 0; i < 3; i++) tick(1);
    check("R2 frozen", {period_left, raw_count}, {16'd6, 16'd0});
    check("R2 idle outs", {mod_gate, comp_src_on, cmp_power, busy}, 0);

    // R8 R9 sweep over polarity, sense, dual
    for (int k = 0; k < 8; k++) begin
      logic p, s, d;
      p = k[0]; s = k[1]; d = k[2];
      wr(0, {26'd0, d, s, 1'b0, 1'b0, p, 1'b1});
      check("R9 comp src", comp_src_on, s & d);
      for (int c = 0; c < 2; c++) begin
        tick(c[0]);
        check("R8 gate", mod_gate, s & (c[0] ^ p));
      end
    end

    // R10 comparator controls
    for (int k = 0; k < 8; k++) begin
      wr(0, {26'd0, 2'b00, 1'b0, k[1], k[2], 1'b0, k[0]});
      check("R10 power", cmp_power, k[0] & k[1]);
      check("R10 bw", cmp_wide_bw, k[2]);
    end

    // R3 R4 R7 conversion sweep
    wr(0, 32'h11);
    for (int p = 1; p <= 24; p++) begin
      for (int s = 1; s <= 3; s++) begin
        int ones;
        ones = 0;
        wr(1, {16'(p), 16'd0});
        check("R7 busy start", {busy, done}, 2'b10);
        for (int i = 0; i < p; i++) begin
          logic c;
          c = ((i * s + p) % 5) < 2;
          ones += c;
          tick(c);
          check("R4 countdown", period_left, p - i - 1);
          repeat (i % 3) @(negedge clk);
        end
        for (int i = 0; i < 3; i++) tick(1);
        check("R3 raw count", raw_count, ones);
        check("R4 stop", period_left, 0);
        check("R7 done", {busy, done}, 2'b01);
      end
    end

    // R5 write beats tick
    wr(1, {16'd5, 16'd0});
    tick(1);
    wr_en = 1; wr_addr = 1; wr_data = {16'd9, 16'd7};
    mod_tick = 1; cmp_in = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0; mod_tick = 0;
    check("R5 write wins", {period_left, raw_count}, {16'd9, 16'd7});

    // R6 saturation
    wr(1, {16'd4, 16'hFFFE});
    for (int i = 0; i < 4; i++) tick(1);
    check("R6 saturate", raw_count, 16'hFFFF);
    check("R6 window end", {period_left, 15'd0, done}, {16'd0, 16'd1});

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule